// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt lines into two processor request outputs. A source can be active because its hardware line is high or because software raised it through a software-request register. A per-source enable mask then gates it, and a per-source route register sends it either to the fast request output or to the normal request output. Software reaches every register through a simple word-addressed read/write port. Read data is registered and appears one cycle after the read strobe.

For the normal request line, sixteen programmable vector slots each bind one source number to a handler address. Reading the vector register returns the address of the highest-priority slot whose source is currently asserting the normal request. If no slot qualifies, it returns a programmable default address. The same read records that slot's priority level. While the level is recorded, only slots of higher priority (lower index) can produce a vector. Each write to the vector register ends the newest service and releases its level, so handlers can nest. Four identification words carry a fixed 32-bit identifier, one byte per word.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset both request outputs are 0. The enable, route, software-request and protection registers read 0, and the nesting record is empty.
- R2: Writing to the enable-set word (0x010) sets every enable bit whose write-data bit is 1. Writing to the enable-clear word (0x014) clears every enable bit whose write-data bit is 1. Zero bits leave enables unchanged. The enable mask reads back at 0x010, and 0x014 reads 0.
- R3: The software-request register has a set word (0x018, which also reads it back) and a clear word (0x01C, which reads 0), both with write-one semantics. Each software bit is ORed with its hardware line, and the raw OR reads at 0x008.
- R4: The route register (0x00C, read/write) sends source n to the fast output when bit n is 1 and to the normal output when bit n is 0.
- R5: The normal status word (0x000) reads (hw OR sw) AND enable AND NOT route. The fast status word (0x004) reads (hw OR sw) AND enable AND route. Each request output is registered and is 1 in the cycle after its status word is nonzero.
- R6: Slot k has an address word at 0x100+4k and a control word at 0x200+4k. Control bit 5 enables the slot and bits 4:0 select its source. A read of the vector word (0x030) returns the address of the lowest-index enabled slot whose source is set in the normal status word.
- R7: When no permitted slot matches, a read of the vector word returns the default-address register (0x034, read/write).
- R8: A vector read that returns a slot's address records that slot's level. While any level is recorded, only slots with a lower index than the newest recorded level can be returned. Any write to the vector word releases the newest recorded level.
- R9: The identification words at 0xFE0, 0xFE4, 0xFE8 and 0xFEC hold bytes 0 to 3 of the identifier in bits 7:0, with upper bits 0. The default identifier carries vendor code 0x75 in bits 19:12.
- R10: The protection word (0x020) holds a read/write bit 0. Reads of unmapped offsets return 0.
- R11: Read data is registered: it is valid in the cycle after the read strobe and is 0 in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Hardware interrupt lines, level-sensitive |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted enable, route or software bit shows up on irq_o or fiq_o in the very next cycle, provided a source line is driven on that bit. The reference model compares both outputs on every clock, so such errors surface at once. A wrong nesting record is silent until the next vector read, which then returns the default address where a slot address was expected, or the reverse. The bench therefore nests and unwinds several levels and follows each release with a read. Errors in slot priority or source decode surface only when two or more slots compete, so overlapping slot programs are exercised.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = ADDR_W - 2;
  typedef logic [WORD_W-1:0] word_t;

  // word indices (byte offset / 4)
  localparam word_t W_IRQ_STAT  = 10'h000;
  localparam word_t W_FIQ_STAT  = 10'h001;
  localparam word_t W_RAW       = 10'h002;
  localparam word_t W_ROUTE     = 10'h003;
  localparam word_t W_EN_SET    = 10'h004;
  localparam word_t W_EN_CLR    = 10'h005;
  localparam word_t W_SOFT_SET  = 10'h006;
  localparam word_t W_SOFT_CLR  = 10'h007;
  localparam word_t W_PROT      = 10'h008;
  localparam word_t W_VEC       = 10'h00C;
  localparam word_t W_DFLT      = 10'h00D;
  localparam word_t W_SLOT_ADDR = 10'h040;
  localparam word_t W_SLOT_CTL  = 10'h080;
  localparam word_t W_ID0       = 10'h3F8;
endpackage

// File: rtl/vic_src_regs.sv
module vic_src_regs
  import vic_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic             we,
  input  word_t            waddr,
  input  logic [DW-1:0]    wdata,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] route_q,
  output logic [N_SRC-1:0] soft_q,
  output logic [N_SRC-1:0] raw,
  output logic [N_SRC-1:0] irq_stat,
  output logic [N_SRC-1:0] fiq_stat
);
  logic [N_SRC-1:0] wbits;
  assign wbits = wdata[N_SRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= '0;
      soft_q  <= '0;
    end else if (we) begin
      case (waddr)
        W_ROUTE:    route_q <= wbits;
        W_EN_SET:   en_q    <= en_q | wbits;
        W_EN_CLR:   en_q    <= en_q & ~wbits;
        W_SOFT_SET: soft_q  <= soft_q | wbits;
        W_SOFT_CLR: soft_q  <= soft_q & ~wbits;
        default: ;
      endcase
    end
  end

  assign raw      = src_i | soft_q;
  assign irq_stat = raw & en_q & ~route_q;
  assign fiq_stat = raw & en_q & route_q;

  a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == W_EN_SET) |=> ((en_q & $past(wbits)) == $past(wbits)));
  a_r2_clr_takes: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == W_EN_CLR) |=> ((en_q & $past(wbits)) == '0));
  a_r2_zero_bits_keep: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == W_EN_SET) |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));
  a_r3_soft_clr_takes: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == W_SOFT_CLR) |=> ((soft_q & $past(wbits)) == '0));
endmodule

// File: rtl/vic_vec_slots.sv
module vic_vec_slots #(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DW     = 32,
  localparam int SRC_W = $clog2(N_SRC),
  localparam int IDX_W = $clog2(N_SLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_stat,
  input  logic             addr_we,
  input  logic             ctl_we,
  input  logic             dflt_we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  input  logic             push,
  input  logic             pop,
  output logic [DW-1:0]    rd_slot_addr,
  output logic [DW-1:0]    rd_slot_ctl,
  output logic [DW-1:0]    dflt_q,
  output logic             found,
  output logic [DW-1:0]    vector
);
  logic [DW-1:0]    va_mem [N_SLOT];
  logic [SRC_W-1:0] ctl_src [N_SLOT];
  logic [N_SLOT-1:0] ctl_en;
  logic [N_SLOT-1:0] nest_q;
  logic [N_SLOT-1:0] hit, allow, lowbit;
  logic [IDX_W-1:0]  win;

  // address storage: plain write port, no reset, block-RAM friendly
  always_ff @(posedge clk) begin
    if (addr_we) va_mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en <= '0;
      dflt_q <= '0;
    end else begin
      if (ctl_we) ctl_en[idx] <= wdata[SRC_W];
      if (dflt_we) dflt_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl_we) ctl_src[idx] <= wdata[SRC_W-1:0];
  end

  generate
    for (genvar k = 0; k < N_SLOT; k++) begin : g_hit
      assign hit[k] = ctl_en[k] & irq_stat[ctl_src[k]];
    end
  endgenerate

  // newest recorded level is the lowest set bit; only lower indices may win
  assign lowbit = nest_q & (~nest_q + 1'b1);
  assign allow  = (nest_q == '0) ? '1 : (lowbit - 1'b1);

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = N_SLOT - 1; k >= 0; k--) begin
      if (hit[k] && allow[k]) begin
        found = 1'b1;
        win   = IDX_W'(k);
      end
    end
  end

  assign vector       = found ? va_mem[win] : dflt_q;
  assign rd_slot_addr = va_mem[idx];
  assign rd_slot_ctl  = DW'({ctl_en[idx], ctl_src[idx]});

  always_ff @(posedge clk) begin
    if (rst) begin
      nest_q <= '0;
    end else if (pop) begin
      nest_q <= nest_q & (nest_q - 1'b1);
    end else if (push && found) begin
      nest_q <= nest_q | (N_SLOT'(1) << win);
    end
  end

  a_r8_pop_releases_one: assert property (@(posedge clk) disable iff (rst)
    (pop && nest_q != '0) |=> ($countones(nest_q) == $countones($past(nest_q)) - 1));
  a_r8_push_records_new: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && found) |=> ($countones(nest_q) == $countones($past(nest_q)) + 1));
  a_r1_nest_empty_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (nest_q == '0));
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
  import vic_pkg::*;
#(
  parameter int          N_SRC   = 32,
  parameter int          N_SLOT  = 16,
  parameter int          DW      = 32,
  parameter logic [31:0] ID_WORD = 32'h0017_5A21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_SRC-1:0]     src_i,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int IDX_W = $clog2(N_SLOT);

  word_t word;
  logic [N_SRC-1:0] en_q, route_q, soft_q, raw, irq_stat, fiq_stat;
  logic [DW-1:0] rd_slot_addr, rd_slot_ctl, dflt_q, vector, rmux;
  logic in_addr, in_ctl, found, prot_q;
  logic [IDX_W-1:0] idx;

  assign word    = bus_addr[ADDR_W-1:2];
  assign in_addr = (word >= W_SLOT_ADDR) && (word < W_SLOT_ADDR + N_SLOT);
  assign in_ctl  = (word >= W_SLOT_CTL)  && (word < W_SLOT_CTL + N_SLOT);
  assign idx     = in_ctl ? IDX_W'(word - W_SLOT_CTL) : IDX_W'(word - W_SLOT_ADDR);

  vic_src_regs #(.N_SRC(N_SRC), .DW(DW)) u_src (
    .clk(clk), .rst(rst), .src_i(src_i), .we(bus_wr), .waddr(word),
    .wdata(bus_wdata), .en_q(en_q), .route_q(route_q), .soft_q(soft_q),
    .raw(raw), .irq_stat(irq_stat), .fiq_stat(fiq_stat));

  vic_vec_slots #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW)) u_vec (
    .clk(clk), .rst(rst), .irq_stat(irq_stat),
    .addr_we(bus_wr && in_addr), .ctl_we(bus_wr && in_ctl),
    .dflt_we(bus_wr && word == W_DFLT), .idx(idx), .wdata(bus_wdata),
    .push(bus_rd && word == W_VEC), .pop(bus_wr && word == W_VEC),
    .rd_slot_addr(rd_slot_addr), .rd_slot_ctl(rd_slot_ctl),
    .dflt_q(dflt_q), .found(found), .vector(vector));

  always_ff @(posedge clk) begin
    if (rst) prot_q <= 1'b0;
    else if (bus_wr && word == W_PROT) prot_q <= bus_wdata[0];
  end

  always_comb begin
    rmux = '0;
    if (in_addr) rmux = rd_slot_addr;
    else if (in_ctl) rmux = rd_slot_ctl;
    else begin
      case (word)
        W_IRQ_STAT: rmux = DW'(irq_stat);
        W_FIQ_STAT: rmux = DW'(fiq_stat);
        W_RAW:      rmux = DW'(raw);
        W_ROUTE:    rmux = DW'(route_q);
        W_EN_SET:   rmux = DW'(en_q);
        W_SOFT_SET: rmux = DW'(soft_q);
        W_PROT:     rmux = DW'(prot_q);
        W_VEC:      rmux = vector;
        W_DFLT:     rmux = dflt_q;
        W_ID0:      rmux = DW'(ID_WORD[7:0]);
        W_ID0 + 1:  rmux = DW'(ID_WORD[15:8]);
        W_ID0 + 2:  rmux = DW'(ID_WORD[23:16]);
        W_ID0 + 3:  rmux = DW'(ID_WORD[31:24]);
        default:    rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rmux : '0;
      irq_o     <= |irq_stat;
      fiq_o     <= |fiq_stat;
    end
  end

  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(en_q & ~route_q)));
  a_r4_fiq_needs_route: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(|(en_q & route_q)));
  a_r7_default_when_no_slot: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && word == W_VEC && !found) |=> (bus_rdata == $past(dflt_q)));
  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/sim_vic_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vic_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] src_i = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, fiq_o;

  always #10 clk = ~clk;

  vic_irq_ctrl u0 (.clk(clk), .rst(rst), .src_i(src_i), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // behavioural reference model
  bit [31:0] m_en, m_sel, m_soft, m_dflt;
  bit        m_prot;
  bit [31:0] m_va [16];
  bit [5:0]  m_ctl [16];
  int        m_stack [$];
  bit        m_irq, m_fiq;

  function automatic bit [31:0] m_stat(bit fast);
    bit [31:0] r = (src_i | m_soft) & m_en;
    return fast ? (r & m_sel) : (r & ~m_sel);
  endfunction

  function automatic int m_slot();
    int limit = (m_stack.size() == 0) ? 16 : m_stack[$];
    bit [31:0] s = m_stat(0);
    for (int k = 0; k < limit; k++)
      if (m_ctl[k][5] && s[m_ctl[k][4:0]]) return k;
    return -1;
  endfunction

  function automatic bit [31:0] m_read(bit [11:0] a);
    int s;
    if (a >= 12'h100 && a < 12'h140) return m_va[(a - 12'h100) >> 2];
    if (a >= 12'h200 && a < 12'h240) return {26'b0, m_ctl[(a - 12'h200) >> 2]};
    case (a)
      12'h000: return m_stat(0);
      12'h004: return m_stat(1);
      12'h008: return src_i | m_soft;
      12'h00C: return m_sel;
      12'h010: return m_en;
      12'h018: return m_soft;
      12'h020: return {31'b0, m_prot};
      12'h030: begin s = m_slot(); return (s < 0) ? m_dflt : m_va[s]; end
      12'h034: return m_dflt;
      12'hFE0: return 32'h21;
      12'hFE4: return 32'h5A;
      12'hFE8: return 32'h17;
      12'hFEC: return 32'h00;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void m_write(bit [11:0] a, bit [31:0] d);
    if (a >= 12'h100 && a < 12'h140) m_va[(a - 12'h100) >> 2] = d;
    else if (a >= 12'h200 && a < 12'h240) m_ctl[(a - 12'h200) >> 2] = d[5:0];
    else case (a)
      12'h00C: m_sel = d;
      12'h010: m_en = m_en | d;
      12'h014: m_en = m_en & ~d;
      12'h018: m_soft = m_soft | d;
      12'h01C: m_soft = m_soft & ~d;
      12'h020: m_prot = d[0];
      12'h030: if (m_stack.size() > 0) void'(m_stack.pop_back());
      12'h034: m_dflt = d;
      default: ;
    endcase
  endfunction

  // request outputs are registered: model them one edge later
  always @(posedge clk) begin
    if (rst) begin m_irq <= 0; m_fiq <= 0; end
    else begin m_irq <= |m_stat(0); m_fiq <= |m_stat(1); end
  end

  // per-clock comparison of both outputs (R5, R4)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 2;
      if (irq_o !== m_irq) begin
        failures++;
        $display("FAIL R5 irq_o actual=%0b expected=%0b cyc=%0d", irq_o, m_irq, cyc);
      end
      if (fiq_o !== m_fiq) begin
        failures++;
        $display("FAIL R4 fiq_o actual=%0b expected=%0b cyc=%0d", fiq_o, m_fiq, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input bit [11:0] a, input bit [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 m_write(a, d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input bit [11:0] a, input string tag);
    bit [31:0] exp;
    int s;
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    exp = m_read(a);
    s = (a == 12'h030) ? m_slot() : -1;
    @(posedge clk);
    #1 if (s >= 0) m_stack.push_back(s);
    @(negedge clk);
    bus_rd = 0;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic drive_src(input bit [31:0] v);
    @(negedge clk);
    src_i = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    rd(12'h010, "R1 enable"); rd(12'h00C, "R1 route");
    rd(12'h018, "R1 soft");   rd(12'h020, "R1 prot");
    // R11: idle cycle after a read returns 0
    @(negedge clk);
    checks++;
    if (bus_rdata !== 32'h0) begin
      failures++; $display("FAIL R11 idle rdata actual=%h expected=0", bus_rdata);
    end
    // R2 set / clear with write-one semantics
    wr(12'h010, 32'h0000_00F0); rd(12'h010, "R2 set");
    wr(12'h014, 32'h0000_0030); rd(12'h010, "R2 clear");
    wr(12'h010, 32'h0000_0000); rd(12'h010, "R2 zero keep");
    rd(12'h014, "R2 clear word reads 0");
    // R5 hardware source through enable
    drive_src(32'h0000_0040); repeat (2) @(negedge clk);
    rd(12'h000, "R5 irq status");
    drive_src(32'h0000_0001); repeat (2) @(negedge clk);
    rd(12'h000, "R5 masked source");
    // R3 soft requests ORed with hardware
    wr(12'h018, 32'h0000_0100); rd(12'h008, "R3 raw");
    wr(12'h010, 32'h0000_0100); rd(12'h000, "R3 soft irq");
    wr(12'h01C, 32'h0000_0100); rd(12'h018, "R3 soft clear");
    rd(12'h01C, "R3 clear word reads 0");
    // R4 route to fast line
    drive_src(32'h0000_0040);
    wr(12'h00C, 32'h0000_0040); rd(12'h004, "R4 fiq status");
    rd(12'h000, "R4 irq status empty");
    wr(12'h00C, 32'h0000_0000);
    drive_src(32'h0);
    // R9 identification, R10 protection and holes
    rd(12'hFE0, "R9 id0"); rd(12'hFE4, "R9 id1");
    rd(12'hFE8, "R9 id2"); rd(12'hFEC, "R9 id3");
    wr(12'h020, 32'h1); rd(12'h020, "R10 prot");
    rd(12'h3F0, "R10 hole"); rd(12'h0FC, "R10 hole2");
    // R6 / R7 / R8 vector slots
    wr(12'h034, 32'd32);
    wr(12'h100, 32'h1000); wr(12'h200, 32'h28);   // slot0 src8
    wr(12'h10C, 32'h3000); wr(12'h20C, 32'h27);   // slot3 src7
    wr(12'h114, 32'h5000); wr(12'h214, 32'h22);   // slot5 src2
    wr(12'h104, 32'h2000); wr(12'h204, 32'h07);   // slot1 disabled
    rd(12'h20C, "R6 ctl readback"); rd(12'h10C, "R6 addr readback");
    wr(12'h010, 32'h0000_0184);
    rd(12'h030, "R7 no source default");
    drive_src(32'h0000_0080);
    rd(12'h030, "R6 slot3 vector");
    drive_src(32'h0000_0084);
    rd(12'h030, "R8 lower priority blocked");
    wr(12'h018, 32'h0000_0100);
    rd(12'h030, "R8 higher priority nests");
    wr(12'h030, 32'h0);
    rd(12'h030, "R8 after pop renest");
    wr(12'h030, 32'h0); wr(12'h030, 32'h0);
    rd(12'h030, "R8 empty record slot0");
    wr(12'h030, 32'h0);
    wr(12'h01C, 32'h0000_0100);
    rd(12'h030, "R6 slot3 again");
    wr(12'h030, 32'h0);
    drive_src(32'h0000_0004);
    rd(12'h030, "R6 slot5");
    wr(12'h030, 32'h0);
    wr(12'h200, 32'h08);
    wr(12'h018, 32'h0000_0100);
    rd(12'h030, "R6 disabled slot skipped");
    wr(12'h030, 32'h0);
    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h030, "R7 all masked");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule